// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This unit gathers three event sources into one active-low interrupt line. The sources are "payload sent", "payload received" and "retry limit reached". Each event pulse sets a sticky status flag. The flag stays set until software writes a one to it. A mask register chooses which flags may pull the interrupt line low. A masked flag is still recorded in the status register.

When a receive event occurs, the unit also records a 3-bit pipe number. This number is shown in a field of the status register. The field is loaded only at the clock edge where the interrupt line goes from inactive to active. While no received payload is pending, the field reads all ones. Software reaches both registers through a single-cycle register port. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: `irq_n_o` is low exactly while at least one status flag is set whose mask bit is 0. It returns high in the cycle after the write that clears the last such flag.
- R2: A one-cycle pulse on an event input sets its flag at the next clock edge. The status register (address 0) holds the flags at bit 0 (sent), bit 1 (received) and bit 2 (retry limit).
- R3: A set flag stays set for as long as no clearing write reaches it.
- R4: A write to address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R5: The mask register is at address 1, bits [2:0], in the same bit order as the flags. A mask bit at 1 keeps its flag from driving `irq_n_o`, but the flag is still set by its event. Clearing the mask bit lets a pending flag drive the line.
- R6: After reset, all flags are clear, all mask bits are 0, `irq_n_o` is high and the pipe field reads 7.
- R7: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: The pipe field is status bits [5:3]. At the clock edge where `irq_n_o` goes from high to low, it takes the pipe number of the most recent receive event. It holds its value while the line stays low.
- R9: The pipe field reads 7 whenever the received flag is clear. Status bits [7:6] and mask-read bits [7:3] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sent_evt_i | input | 1 | Payload-sent event pulse |
| recv_evt_i | input | 1 | Payload-received event pulse |
| retry_evt_i | input | 1 | Retry-limit event pulse |
| recv_pipe_i | input | 3 | Pipe number that comes with a receive event |
| addr_i | input | 1 | Register select: 0 status, 1 mask |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 3 | Write data (flag-clear bits or mask bits) |
| rd_data_o | output | DATA_W | Combinational read data for `addr_i` |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
An event pulse and a write-one-to-clear on the same flag can land in the same cycle. The bench provokes this by raising the sent event in the cycle that also writes a one to flag bit 0, and it expects the flag to read back set with the line low. The second overlap is between a mask write and the assertion edge. The bench records a receive event while its mask bit is set, then clears the mask. It expects the line to fall and the pipe field to be loaded in that same write cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC   = 3;
  localparam int PIPE_W    = 3;
  localparam int SRC_SENT  = 0;
  localparam int SRC_RECV  = 1;
  localparam int SRC_RETRY = 2;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic d_o,
  output logic q_o
);
  // set has priority over clear
  assign d_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_o;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);
  assign d_o = wr_i ? data_i : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_o;
  end
endmodule

// File: rtl/irq_pipe_track.sv
module irq_pipe_track #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         recv_evt_i,
  input  logic [W-1:0] recv_pipe_i,
  input  logic         pend_d_i,
  input  logic         edge_i,
  output logic [W-1:0] pipe_o
);
  logic [W-1:0] held_q, pipe_d, latest;

  assign latest = recv_evt_i ? recv_pipe_i : held_q;

  always_comb begin
    pipe_d = pipe_o;
    if (!pend_d_i)   pipe_d = '1;
    else if (edge_i) pipe_d = latest;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '1;
      pipe_o <= '1;
    end else begin
      held_q <= latest;
      pipe_o <= pipe_d;
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sent_evt_i,
  input  logic              recv_evt_i,
  input  logic              retry_evt_i,
  input  logic [PIPE_W-1:0] recv_pipe_i,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o
);
  localparam int FIELD_W = NUM_SRC + PIPE_W;

  logic [NUM_SRC-1:0] evt, clr, stat_d, stat_q, mask_d, mask_q;
  logic [PIPE_W-1:0]  pipe_q;
  logic wr_stat, wr_mask, act_q, act_d, assert_edge;

  assign evt     = {retry_evt_i, recv_evt_i, sent_evt_i};
  assign wr_stat = wr_en_i && (addr_i == ADDR_STATUS);
  assign wr_mask = wr_en_i && (addr_i == ADDR_MASK);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign clr[g] = wr_stat & wr_data_i[g];
    irq_sticky_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[g]),
      .clr_i  (clr[g]),
      .d_o    (stat_d[g]),
      .q_o    (stat_q[g])
    );
  end

  irq_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_mask),
    .data_i (wr_data_i),
    .d_o    (mask_d),
    .q_o    (mask_q)
  );

  assign act_q       = |(stat_q & ~mask_q);
  assign act_d       = |(stat_d & ~mask_d);
  assign assert_edge = act_d & ~act_q;
  assign irq_n_o     = ~act_q;

  irq_pipe_track #(.W(PIPE_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .recv_evt_i  (recv_evt_i),
    .recv_pipe_i (recv_pipe_i),
    .pend_d_i    (stat_d[SRC_RECV]),
    .edge_i      (assert_edge),
    .pipe_o      (pipe_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_MASK) begin
      rd_data_o[NUM_SRC-1:0] = mask_q;
    end else begin
      rd_data_o[NUM_SRC-1:0]       = stat_q;
      rd_data_o[FIELD_W-1:NUM_SRC] = pipe_q;
    end
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sent_evt_i,
  input logic               recv_evt_i,
  input logic               retry_evt_i,
  input logic               addr_i,
  input logic               wr_en_i,
  input logic [NUM_SRC-1:0] wr_data_i,
  input logic               irq_n_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [PIPE_W-1:0]  pipe_q
);
  logic [NUM_SRC-1:0] evt;
  logic wr_stat;
  assign evt     = {retry_evt_i, recv_evt_i, sent_evt_i};
  assign wr_stat = wr_en_i && (addr_i == ADDR_STATUS);

  p_line_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_n_o == ((stat_q & ~mask_q) == '0));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    p_evt_sets_r2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[g] |=> stat_q[g]);
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[g] && !(wr_stat && wr_data_i[g])) |=> stat_q[g]);
    p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && wr_data_i[g] && !evt[g]) |=> !stat_q[g]);
    p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_q[g] && !evt[g]) |=> !stat_q[g]);
  end

  p_pipe_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[SRC_RECV] |-> (pipe_q == '1));

  p_pipe_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_n_o && stat_q[SRC_RECV]) |=> (!stat_q[SRC_RECV] || $stable(pipe_q)));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sent_evt_i  (sent_evt_i),
  .recv_evt_i  (recv_evt_i),
  .retry_evt_i (retry_evt_i),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .irq_n_o     (irq_n_o),
  .stat_q      (stat_q),
  .mask_q      (mask_q),
  .pipe_q      (pipe_q)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sent_evt = 1'b0, recv_evt = 1'b0, retry_evt = 1'b0;
  logic [2:0] recv_pipe = 3'd0;
  logic       addr = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic [7:0] rd_data;
  logic       irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sent_evt_i  (sent_evt),
    .recv_evt_i  (recv_evt),
    .retry_evt_i (retry_evt),
    .recv_pipe_i (recv_pipe),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .irq_n_o     (irq_n)
  );

  task automatic chk_rd(input logic a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d read 0x%02h expected 0x%02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_n !== exp) begin
      fails++;
      $display("FAIL %s: irq_n %b expected %b", tag, irq_n, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [2:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 3'd0;
  endtask

  task automatic pulse(input logic [2:0] e, input logic [2:0] p);
    @(negedge clk);
    {retry_evt, recv_evt, sent_evt} = e; recv_pipe = p;
    @(negedge clk);
    {retry_evt, recv_evt, sent_evt} = 3'b000;
  endtask

  task automatic t_reset;
    chk_irq(1'b1, "R6 irq idle");
    chk_rd(1'b0, 8'h38, "R6 R9 status after reset");
    chk_rd(1'b1, 8'h00, "R6 mask after reset");
  endtask

  task automatic t_sent;
    pulse(3'b001, 3'd0);
    chk_rd(1'b0, 8'h39, "R2 sent flag");
    chk_irq(1'b0, "R1 line low");
    repeat (3) @(negedge clk);
    chk_rd(1'b0, 8'h39, "R3 flag held");
    wr(1'b0, 3'b110);
    chk_rd(1'b0, 8'h39, "R4 zero bit no effect");
    chk_irq(1'b0, "R4 line still low");
    wr(1'b0, 3'b001);
    chk_rd(1'b0, 8'h38, "R4 cleared");
    chk_irq(1'b1, "R1 line released");
  endtask

  task automatic t_recv;
    pulse(3'b010, 3'd5);
    chk_rd(1'b0, 8'h2A, "R8 pipe captured");
    chk_irq(1'b0, "R1 recv low");
    pulse(3'b010, 3'd3);
    chk_rd(1'b0, 8'h2A, "R8 pipe held while low");
    wr(1'b0, 3'b010);
    chk_rd(1'b0, 8'h38, "R9 pipe back to 7");
    chk_irq(1'b1, "R1 recv released");
  endtask

  task automatic t_mask;
    wr(1'b1, 3'b100);
    chk_rd(1'b1, 8'h04, "R5 mask readback");
    pulse(3'b100, 3'd0);
    chk_rd(1'b0, 8'h3C, "R5 masked flag still set");
    chk_irq(1'b1, "R5 masked no irq");
    wr(1'b1, 3'b000);
    chk_irq(1'b0, "R5 unmask drives line");
    wr(1'b0, 3'b100);
    chk_rd(1'b0, 8'h38, "R4 retry cleared");
    chk_irq(1'b1, "R1 retry released");
  endtask

  task automatic t_collision;
    @(negedge clk);
    sent_evt = 1'b1; addr = 1'b0; wr_data = 3'b001; wr_en = 1'b1;
    @(negedge clk);
    sent_evt = 1'b0; wr_en = 1'b0; wr_data = 3'd0;
    chk_rd(1'b0, 8'h39, "R7 event wins");
    chk_irq(1'b0, "R7 line low");
    wr(1'b0, 3'b001);
    chk_rd(1'b0, 8'h38, "R4 clear after collision");
  endtask

  task automatic t_edge_capture;
    wr(1'b1, 3'b010);
    pulse(3'b010, 3'd4);
    chk_rd(1'b0, 8'h3A, "R8 no edge no capture");
    chk_irq(1'b1, "R5 recv masked");
    wr(1'b1, 3'b000);
    chk_rd(1'b0, 8'h22, "R8 captured on unmask edge");
    chk_irq(1'b0, "R8 line low");
    wr(1'b0, 3'b010);
    chk_rd(1'b0, 8'h38, "R9 idle pipe");
  endtask

  task automatic t_multi;
    pulse(3'b101, 3'd0);
    chk_rd(1'b0, 8'h3D, "R2 two flags");
    wr(1'b0, 3'b001);
    chk_rd(1'b0, 8'h3C, "R4 partial clear");
    chk_irq(1'b0, "R1 still low");
    wr(1'b0, 3'b100);
    chk_irq(1'b1, "R1 released after last");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sent();
    t_recv();
    t_mask();
    t_collision();
    t_edge_capture();
    t_multi();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule